// File: doc/BRIEF.md
# Non-Maskable Interrupt Flag Unit

This unit collects error strobes from several hardware monitors into sticky flag bits and turns the first of them into a single non-maskable interrupt request. A global interrupt flag records that a request has been raised. While that flag is set, no further request pulses are produced, however many new errors arrive. Software reads the flags over a simple single-cycle register port. It acknowledges events by writing ones to a write-one-to-clear register.

A second, read-only copy of the source flags keeps a record of every error seen. Only the self-test error bit of that copy can be cleared by software. If a monitor raises a bit in the same cycle that software clears it, the hardware set wins. Software is expected to clear the source flags first and the global flag last. If anything is still pending when the global flag is cleared, the unit raises a fresh request so that no event is lost.

Top module: `nmi_flag_unit`

## Requirements
- R1: After reset, and after any later reset, the flag register, the shadow register and `nmi_pulse` are all 0.
- R2: A strobe on a source bit (bit 1 = clock failure, bits 4 to 9 = error sources, bit 5 being self-test) sets that bit in the flag register (address 0x0) from the cycle after the strobe, and it stays set until cleared.
- R3: A valid source strobe while the global flag (bit 0) is 0 sets bit 0 and drives `nmi_pulse` high for exactly one cycle, in the cycle after the strobe.
- R4: While bit 0 of the flag register is 1, `nmi_pulse` stays 0 whatever strobes arrive.
- R5: Writing the clear register (address 0x1) clears every flag bit written as 1 and leaves every bit written as 0 unchanged.
- R6: When a strobe and a clear of the same bit fall in one cycle, the bit reads 1 afterwards.
- R7: The global flag falls only on a clear-register write with bit 0 set, or on reset. Clearing source bits alone leaves it at 1.
- R8: If source flags are still set when the global flag is cleared, bit 0 reads 0 for one cycle, and then a new one-cycle pulse is raised with bit 0 set again.
- R9: The shadow register (address 0x2) sets each bit together with the flag register. A clear write removes only bit 5 from it. Its other bits fall only on reset.
- R10: Bits 2, 3 and 10 to 31 of every register read 0. Strobes on bits 0, 2 and 3 have no effect. The clear register always reads 0.
- R11: Writes to the flag register and the shadow register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| src_strobe | input | 10 | One-cycle error strobes, one per flag bit position |
| reg_addr | input | 4 | Register address: 0x0 flags, 0x1 clear, 0x2 shadow |
| reg_wen | input | 1 | Write enable, single cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The first strobe is applied alone on an idle unit. The test then checks that it raises both the source bit and a pulse, and that a second strobe while the global flag is set raises only its own bit. Clear writes are tried with the source flags cleared first, with the global flag cleared while sources are still pending, and with both cleared together. This shows the difference between a refire and a clean return to idle. Strobes and clears on the same bit in one cycle, an all-ones clear word, strobes on reserved positions, and writes to the read-only addresses show that the set has priority, that bit 5 alone leaves the shadow copy, and that the reserved bits ignore all stimulus.

// File: rtl/nmi_flag_pkg.sv
package nmi_flag_pkg;
  localparam int FLAG_W       = 10;
  localparam int GLOBAL_BIT   = 0;
  localparam int SELFTEST_BIT = 5;
  // source positions: clock failure (1) and errors (4..9)
  localparam logic [FLAG_W-1:0] SRC_MASK    = 10'b11_1111_0010;
  localparam logic [FLAG_W-1:0] SHD_CLR_MASK = 10'b00_0010_0000;

  // sticky bit update: a set beats a clear
  function automatic logic sticky_next(input logic set, input logic clr, input logic cur);
    return set | (cur & ~clr);
  endfunction

  // vector form of the same rule
  function automatic logic [FLAG_W-1:0] sticky_vec(input logic [FLAG_W-1:0] set,
                                                  input logic [FLAG_W-1:0] clr,
                                                  input logic [FLAG_W-1:0] cur);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/nmi_src_flags.sv
module nmi_src_flags
  import nmi_flag_pkg::*;
#(
  parameter int                FW       = FLAG_W,
  parameter logic [FW-1:0]     SMASK    = SRC_MASK,
  parameter logic [FW-1:0]     SHD_MASK = SHD_CLR_MASK
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] strobe,
  input  logic [FW-1:0] clr,
  output logic [FW-1:0] flags_q,
  output logic [FW-1:0] shadow_q,
  output logic          any_strobe,
  output logic          any_pending
);
  logic [FW-1:0] set_v;
  logic [FW-1:0] shd_clr;

  assign set_v       = strobe & SMASK;
  assign shd_clr     = clr & SHD_MASK;
  assign any_strobe  = |set_v;
  assign any_pending = |flags_q;

  for (genvar i = 0; i < FW; i++) begin : g_bit
    if (SMASK[i]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flags_q[i]  <= 1'b0;
          shadow_q[i] <= 1'b0;
        end else begin
          flags_q[i]  <= sticky_next(set_v[i], clr[i], flags_q[i]);
          shadow_q[i] <= sticky_next(set_v[i], shd_clr[i], shadow_q[i]);
        end
      end

      // R6
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe[i] |=> (flags_q[i] && shadow_q[i]));

      // R5
      clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !strobe[i]) |=> !flags_q[i]);

      if (!SHD_MASK[i]) begin : g_keep
        // R9
        shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
          shadow_q[i] |=> shadow_q[i]);
      end
    end else begin : g_rsv
      assign flags_q[i]  = 1'b0;
      assign shadow_q[i] = 1'b0;
    end
  end

  logic unused_rsv;
  assign unused_rsv = ^(clr & ~SMASK);
endmodule

// File: rtl/nmi_global_ctrl.sv
module nmi_global_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_strobe,
  input  logic any_pending,
  input  logic clr_global,
  output logic gflag_q,
  output logic nmi_pulse
);
  logic fire;

  // raise a request on new or still-pending events while idle
  assign fire = !gflag_q && (any_strobe || any_pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gflag_q   <= 1'b0;
      nmi_pulse <= 1'b0;
    end else begin
      gflag_q   <= fire | (gflag_q & ~clr_global);
      nmi_pulse <= fire;
    end
  end

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |=> !nmi_pulse);

  // R4
  pulse_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |-> $rose(gflag_q));

  // R7
  global_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gflag_q && !clr_global) |=> gflag_q);

  // R8
  pend_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gflag_q && any_pending) |=> (nmi_pulse && gflag_q));
endmodule

// File: rtl/nmi_reg_port.sv
module nmi_reg_port #(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 4,
  parameter int                FW       = 10,
  parameter logic [ADDR_W-1:0] FLG_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 4'h1,
  parameter logic [ADDR_W-1:0] SHD_ADDR = 4'h2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [FW-1:0]     flags_all,
  input  logic [FW-1:0]     shadow_all,
  output logic [FW-1:0]     clr,
  output logic [DATA_W-1:0] reg_rdata
);
  logic clr_hit;

  assign clr_hit = reg_wen && (reg_addr == CLR_ADDR);
  assign clr     = clr_hit ? reg_wdata[FW-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == FLG_ADDR)      reg_rdata[FW-1:0] = flags_all;
    else if (reg_addr == SHD_ADDR) reg_rdata[FW-1:0] = shadow_all;
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:FW];

  // R10
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DATA_W-1:FW] == '0) && (reg_rdata[3:2] == 2'b00));

  // R10
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CLR_ADDR) |-> (reg_rdata == '0));
endmodule

// File: rtl/nmi_flag_unit.sv
module nmi_flag_unit
  import nmi_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] src_strobe,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              nmi_pulse
);
  logic [FLAG_W-1:0] clr;
  logic [FLAG_W-1:0] src_flags;
  logic [FLAG_W-1:0] shadow;
  logic [FLAG_W-1:0] flags_all;
  logic              any_strobe;
  logic              any_pending;
  logic              gflag;

  nmi_src_flags #(.FW(FLAG_W), .SMASK(SRC_MASK), .SHD_MASK(SHD_CLR_MASK)) flags_i (
    .clk(clk), .rst_n(rst_n), .strobe(src_strobe), .clr(clr),
    .flags_q(src_flags), .shadow_q(shadow),
    .any_strobe(any_strobe), .any_pending(any_pending)
  );

  nmi_global_ctrl glob_i (
    .clk(clk), .rst_n(rst_n), .any_strobe(any_strobe), .any_pending(any_pending),
    .clr_global(clr[GLOBAL_BIT]), .gflag_q(gflag), .nmi_pulse(nmi_pulse)
  );

  always_comb begin
    flags_all             = src_flags;
    flags_all[GLOBAL_BIT] = gflag;
  end

  nmi_reg_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FW(FLAG_W)) port_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .flags_all(flags_all), .shadow_all(shadow),
    .clr(clr), .reg_rdata(reg_rdata)
  );

  // R2
  src_sets_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_flags) |=> (gflag || $past(clr[GLOBAL_BIT]) || !$past(gflag)));
endmodule

// File: tb/nmi_flag_unit_tb.sv
module nmi_flag_unit_tb_top;
  typedef struct packed {
    logic [9:0]  strb;
    logic        wen;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic        pulse;
    logic [9:0]  flag;
    logic [9:0]  shad;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{10'h040, 1'b0, 4'h0, 32'h0,        1'b1, 10'h041, 10'h040, 4'd3},  // R3 first strobe
    '{10'h010, 1'b0, 4'h0, 32'h0,        1'b0, 10'h051, 10'h050, 4'd4},  // R4 masked pulse
    '{10'h000, 1'b1, 4'h1, 32'h40,       1'b0, 10'h011, 10'h050, 4'd5},  // R5 clear bit 6
    '{10'h000, 1'b1, 4'h1, 32'h1,        1'b0, 10'h010, 10'h050, 4'd8},  // R8 global cleared
    '{10'h000, 1'b0, 4'h0, 32'h0,        1'b1, 10'h011, 10'h050, 4'd8},  // R8 refire
    '{10'h010, 1'b1, 4'h1, 32'h10,       1'b0, 10'h011, 10'h050, 4'd6},  // R6 set wins
    '{10'h000, 1'b1, 4'h1, 32'h11,       1'b0, 10'h000, 10'h050, 4'd7},  // R7 clear both
    '{10'h000, 1'b0, 4'h0, 32'h0,        1'b0, 10'h000, 10'h050, 4'd8},  // R8 no refire
    '{10'h00D, 1'b0, 4'h0, 32'h0,        1'b0, 10'h000, 10'h050, 4'd10}, // R10 reserved strobes
    '{10'h020, 1'b0, 4'h0, 32'h0,        1'b1, 10'h021, 10'h070, 4'd2},  // R2 self-test
    '{10'h000, 1'b1, 4'h1, 32'h20,       1'b0, 10'h001, 10'h050, 4'd9},  // R9 bit 5 shadow clr
    '{10'h000, 1'b1, 4'h1, 32'hFFFFFFF0, 1'b0, 10'h001, 10'h050, 4'd9},  // R9 others stay
    '{10'h000, 1'b1, 4'h0, 32'h0,        1'b0, 10'h001, 10'h050, 4'd11}, // R11 flag reg write
    '{10'h000, 1'b1, 4'h2, 32'h0,        1'b0, 10'h001, 10'h050, 4'd11}, // R11 shadow write
    '{10'h3F2, 1'b0, 4'h0, 32'h0,        1'b0, 10'h3F3, 10'h3F2, 4'd4},  // R4 all sources
    '{10'h002, 1'b1, 4'h1, 32'h3F3,      1'b0, 10'h002, 10'h3D2, 4'd6},  // R6 bit 1 survives
    '{10'h000, 1'b0, 4'h0, 32'h0,        1'b1, 10'h003, 10'h3D2, 4'd8}   // R8 refire on bit 1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  src_strobe = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  nmi_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .src_strobe(src_strobe), .reg_addr(reg_addr),
    .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_pulse(nmi_pulse)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 state held in reset
    chk("R1", "pulse in reset", {31'b0, nmi_pulse}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, d); chk("R1", "flags after reset", d, 32'h0);
    rd(4'h2, d); chk("R1", "shadow after reset", d, 32'h0);
    reg_addr = 4'h0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      src_strobe = VEC[i].strb;
      reg_wen    = VEC[i].wen;
      reg_addr   = VEC[i].addr;
      reg_wdata  = VEC[i].wdata;
      @(negedge clk);
      src_strobe = '0;
      reg_wen    = 1'b0;
      reg_wdata  = '0;
      chk(tag, "pulse", {31'b0, nmi_pulse}, {31'b0, VEC[i].pulse});
      rd(4'h0, d); chk(tag, "flags", d, {22'b0, VEC[i].flag});
      rd(4'h2, d); chk(tag, "shadow", d, {22'b0, VEC[i].shad});
      reg_addr = 4'h0;
    end

    // R10 clear register reads 0 with flags pending
    rd(4'h1, d); chk("R10", "clear reg readback", d, 32'h0);
    reg_addr = 4'h0;

    // R3 pulse was one cycle: next cycle low
    @(negedge clk);
    chk("R3", "pulse width", {31'b0, nmi_pulse}, 32'h0);

    // R1 reset mid-run clears everything
    rst_n = 1'b0;
    #2;
    chk("R1", "pulse on reset", {31'b0, nmi_pulse}, 32'h0);
    rd(4'h0, d); chk("R1", "flags on reset", d, 32'h0);
    rd(4'h2, d); chk("R1", "shadow on reset", d, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, d); chk("R1", "flags after reset release", d, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule